// File: doc/BRIEF.md
# Video input format decoder

This block sits at the front of a video encoder datapath. It takes digital video words on up to three 10-bit buses. The buses are clocked at twice the pixel rate. The block turns them into one 4:4:4 YCbCr pixel per two input clocks, with a valid strobe and active-low sync outputs that line up with the pixel data. A divide-by-two copy of the input clock is also driven out as a pixel clock.

A two-bit format select picks one of four input formats:

- **Multiplexed 10-bit, embedded timing.** Chroma and luma words share one bus. Horizontal, vertical, field and blanking state come from timing reference codes inside the stream.
- **Multiplexed 10-bit, external timing.** The same word stream, but timing comes from active-low pins.
- **20-bit.** Luma and multiplexed chroma arrive on separate buses.
- **4:4:4 pass-through.** RGB or YCbCr 4:4:4 arrives on all three buses.

The three 4:2:2 formats are expanded to 4:4:4 by repeating each chroma pair. They are then clamped to the legal code range, or to an extended range when the range select is high. Pass-through pixels are forwarded without clamping.

Top module: `vid_in_decoder`

## Requirements
- R1: While reset is held, and until the first clock edge after its release, the outputs are as follows:
  - pix_valid, pix_clk, field_out and all data outputs are 0.
  - hs_n_out, vs_n_out and blank_n_out are 1.
- R2: After reset, pix_clk inverts on every clk2x rising edge, starting from 0.
- R3: Each input word has a word index 0..3, and the index advances by one (mod 4) per clk2x cycle.
  - pix_valid is 1 for exactly the cycle after a word with an odd index, and 0 otherwise, so it is never high in two consecutive cycles.
  - All data and sync outputs change only together with a strobe.
- R4: Format select 0 (embedded timing) recognises a timing reference: the words 0x3FF, 0x000, 0x000 followed by a control word.
  - In the control word, bit 8 is the field flag, bit 7 is the vertical flag and bit 6 is the horizontal flag. Bits 5..0 are ignored.
  - The flags take effect for pixels emitted after the control word. Each pixel carries field_out = field flag, vs_n_out = not vertical, hs_n_out = not horizontal, and blank_n_out = not (horizontal or vertical).
  - A control word with horizontal flag 0 (start of active video) makes the next word index 0.
- R5: In format select 0 and 1, the bus luma_in carries Cb at index 0, Y0 at index 1, Cr at index 2 and Y1 at index 3.
  - The strobe after index 3 carries (Y0, Cb, Cr).
  - The strobe after the next index 1 carries (Y1, Cb, Cr) with the same chroma pair.
- R6: In format select 1, 2 and 3, a word cycle in which blank_n_in is 1 after being 0 the cycle before has index 0.
  - Each emitted pixel copies vs_n_in, hs_n_in and blank_n_in as sampled in its emitting word cycle.
  - field_out is 0 in these formats.
- R7: In format select 2, only odd-index cycles are sampled. Index 1 gives Y0 from luma_in and Cb from chroma_in. Index 3 gives Y1 from luma_in and Cr from chroma_in. Emission follows the same schedule and chroma repetition as R5.
- R8: With ext_range 0, formats 0 to 2 clamp each of y_out, cb_out and cr_out to 64..940.
- R9: With ext_range 1, formats 0 to 2 clamp each of y_out, cb_out and cr_out to 4..1016.
- R10: In format select 3, the strobe after each odd-index word carries y_out = luma_in, cb_out = aux_in and cr_out = chroma_in from that word, unclamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Input word clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | 0 embedded timing, 1 external timing, 2 20-bit, 3 pass-through |
| ext_range | input | 1 | 1 selects the extended clamp range |
| luma_in | input | 10 | Multiplexed stream, or luma / G |
| chroma_in | input | 10 | Multiplexed Cb/Cr (20-bit), or Cr / R |
| aux_in | input | 10 | Cb / B in pass-through |
| vs_n_in | input | 1 | External vertical sync, active low |
| hs_n_in | input | 1 | External horizontal sync, active low |
| blank_n_in | input | 1 | External blanking, active low |
| pix_clk | output | 1 | clk2x divided by two |
| pix_valid | output | 1 | One-cycle strobe per emitted pixel |
| y_out | output | 10 | Luma / G |
| cb_out | output | 10 | Cb / B |
| cr_out | output | 10 | Cr / R |
| hs_n_out | output | 1 | Horizontal sync, active low |
| vs_n_out | output | 1 | Vertical sync, active low |
| blank_n_out | output | 1 | Blanking, active low |
| field_out | output | 1 | Field flag |

## Verification
The properties assume that fmt_sel and ext_range change only while reset is held, since the clamp and field checks look back at them by one cycle. The stimulus therefore sets both inside every reset pulse and never touches them afterwards. Inputs are driven on the falling edge and held for a full word cycle. In the embedded format, active and blanking data words stay within 1..1022, so that no data word can mimic the start of a timing reference. In the other formats, each active run is preceded by a low blank_n_in interval, so that group alignment is always re-established by a rising edge.

// File: rtl/vid_in_decoder.sv
module vid_in_decoder #(
  parameter int W        = 10,
  parameter int LEGAL_LO = 64,
  parameter int LEGAL_HI = 940,
  parameter int EXT_LO   = 4,
  parameter int EXT_HI   = 1016
) (
  input  logic         clk2x,
  input  logic         rst_n,
  input  logic [1:0]   fmt_sel,
  input  logic         ext_range,
  input  logic [W-1:0] luma_in,
  input  logic [W-1:0] chroma_in,
  input  logic [W-1:0] aux_in,
  input  logic         vs_n_in,
  input  logic         hs_n_in,
  input  logic         blank_n_in,
  output logic         pix_clk,
  output logic         pix_valid,
  output logic [W-1:0] y_out,
  output logic [W-1:0] cb_out,
  output logic [W-1:0] cr_out,
  output logic         hs_n_out,
  output logic         vs_n_out,
  output logic         blank_n_out,
  output logic         field_out
);
  localparam logic [1:0] M_EMB  = 2'd0;
  localparam logic [1:0] M_MUX  = 2'd1;
  localparam logic [1:0] M_PASS = 2'd3;
  localparam logic [W-1:0] ALLONE = '1;
  localparam logic [W-1:0] L_LO = W'(LEGAL_LO);
  localparam logic [W-1:0] L_HI = W'(LEGAL_HI);
  localparam logic [W-1:0] X_LO = W'(EXT_LO);
  localparam logic [W-1:0] X_HI = W'(EXT_HI);
  localparam int FB = W - 2;
  localparam int VB = W - 3;
  localparam int HB = W - 4;

  logic [1:0]   wc;
  logic         blank_q;
  logic [W-1:0] h0, h1, h2;
  logic         f_q, v_q, h_q;
  logic [W-1:0] cb_q, cr_q, y0_q, y1_q, pcb_q, pcr_q;

  wire          is_mux   = (fmt_sel == M_EMB) || (fmt_sel == M_MUX);
  wire          ext_rise = (fmt_sel != M_EMB) && blank_n_in && !blank_q;
  wire [1:0]    idx      = ext_rise ? 2'd0 : wc;
  wire          trs      = (fmt_sel == M_EMB) && (h2 == ALLONE) && (h1 == '0) && (h0 == '0);
  wire          sav      = trs && !luma_in[HB];
  wire [W-1:0]  cr_now   = is_mux ? cr_q : chroma_in;
  wire [W-1:0]  lo       = ext_range ? X_LO : L_LO;
  wire [W-1:0]  hi       = ext_range ? X_HI : L_HI;

  logic [W-1:0] sel_y, sel_cb, sel_cr;
  logic         s_hs, s_vs, s_bl, s_fd;

  function automatic logic [W-1:0] lim(input logic [W-1:0] v, input logic [W-1:0] a,
                                       input logic [W-1:0] b, input logic bypass);
    if (bypass) return v;
    if (v < a) return a;
    if (v > b) return b;
    return v;
  endfunction

  always_comb begin
    if (fmt_sel == M_PASS) begin
      sel_y  = luma_in;
      sel_cb = aux_in;
      sel_cr = chroma_in;
    end else if (idx == 2'd3) begin
      sel_y  = y0_q;
      sel_cb = cb_q;
      sel_cr = cr_now;
    end else begin
      sel_y  = y1_q;
      sel_cb = pcb_q;
      sel_cr = pcr_q;
    end
    if (fmt_sel == M_EMB) begin
      s_hs = !h_q;
      s_vs = !v_q;
      s_bl = !(h_q || v_q);
      s_fd = f_q;
    end else begin
      s_hs = hs_n_in;
      s_vs = vs_n_in;
      s_bl = blank_n_in;
      s_fd = 1'b0;
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      pix_clk     <= 1'b0;
      wc          <= 2'd0;
      blank_q     <= 1'b1;
      h0          <= '0;
      h1          <= '0;
      h2          <= '0;
      f_q         <= 1'b0;
      v_q         <= 1'b0;
      h_q         <= 1'b0;
      cb_q        <= '0;
      cr_q        <= '0;
      y0_q        <= '0;
      y1_q        <= '0;
      pcb_q       <= '0;
      pcr_q       <= '0;
      pix_valid   <= 1'b0;
      y_out       <= '0;
      cb_out      <= '0;
      cr_out      <= '0;
      hs_n_out    <= 1'b1;
      vs_n_out    <= 1'b1;
      blank_n_out <= 1'b1;
      field_out   <= 1'b0;
    end else begin
      pix_clk <= ~pix_clk;
      blank_q <= blank_n_in;
      h2      <= h1;
      h1      <= h0;
      h0      <= luma_in;
      if (trs) begin
        f_q <= luma_in[FB];
        v_q <= luma_in[VB];
        h_q <= luma_in[HB];
      end
      wc        <= sav ? 2'd0 : idx + 2'd1;
      pix_valid <= idx[0];
      case (idx)
        2'd0: if (is_mux) cb_q <= luma_in;
        2'd1: begin
          y0_q <= luma_in;
          if (!is_mux) cb_q <= chroma_in;
        end
        2'd2: if (is_mux) cr_q <= luma_in;
        default: begin
          y1_q  <= luma_in;
          pcb_q <= cb_q;
          pcr_q <= cr_now;
        end
      endcase
      if (idx[0]) begin
        y_out       <= lim(sel_y,  lo, hi, fmt_sel == M_PASS);
        cb_out      <= lim(sel_cb, lo, hi, fmt_sel == M_PASS);
        cr_out      <= lim(sel_cr, lo, hi, fmt_sel == M_PASS);
        hs_n_out    <= s_hs;
        vs_n_out    <= s_vs;
        blank_n_out <= s_bl;
        field_out   <= s_fd;
      end
    end
  end
endmodule

// File: rtl/vid_in_decoder_chk.sv
module vid_in_decoder_chk #(
  parameter int W        = 10,
  parameter int LEGAL_LO = 64,
  parameter int LEGAL_HI = 940,
  parameter int EXT_LO   = 4,
  parameter int EXT_HI   = 1016
) (
  input logic         clk2x,
  input logic         rst_n,
  input logic [1:0]   fmt_sel,
  input logic         ext_range,
  input logic         pix_clk,
  input logic         pix_valid,
  input logic [W-1:0] y_out,
  input logic [W-1:0] cb_out,
  input logic [W-1:0] cr_out,
  input logic         hs_n_out,
  input logic         vs_n_out,
  input logic         blank_n_out,
  input logic         field_out
);
  localparam logic [W-1:0] L_LO = W'(LEGAL_LO);
  localparam logic [W-1:0] L_HI = W'(LEGAL_HI);
  localparam logic [W-1:0] X_LO = W'(EXT_LO);
  localparam logic [W-1:0] X_HI = W'(EXT_HI);

  a_r2_pix_clk_toggles: assert property (@(posedge clk2x) disable iff (!rst_n)
    1'b1 |=> (pix_clk != $past(pix_clk)));

  a_r3_strobe_gap: assert property (@(posedge clk2x) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  a_r3_hold_between: assert property (@(posedge clk2x) disable iff (!rst_n)
    !pix_valid |-> ($stable(y_out) && $stable(cb_out) && $stable(cr_out) &&
                    $stable(hs_n_out) && $stable(vs_n_out) && $stable(blank_n_out) &&
                    $stable(field_out)));

  a_r8_legal_range: assert property (@(posedge clk2x) disable iff (!rst_n)
    (pix_valid && $past(fmt_sel) != 2'd3 && !$past(ext_range)) |->
      (y_out >= L_LO && y_out <= L_HI && cb_out >= L_LO && cb_out <= L_HI &&
       cr_out >= L_LO && cr_out <= L_HI));

  a_r9_ext_range: assert property (@(posedge clk2x) disable iff (!rst_n)
    (pix_valid && $past(fmt_sel) != 2'd3 && $past(ext_range)) |->
      (y_out >= X_LO && y_out <= X_HI && cb_out >= X_LO && cb_out <= X_HI &&
       cr_out >= X_LO && cr_out <= X_HI));

  a_r6_field_low: assert property (@(posedge clk2x) disable iff (!rst_n)
    (pix_valid && $past(fmt_sel) != 2'd0) |-> !field_out);
endmodule

bind vid_in_decoder vid_in_decoder_chk #(
  .W(W), .LEGAL_LO(LEGAL_LO), .LEGAL_HI(LEGAL_HI), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
) u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .fmt_sel(fmt_sel), .ext_range(ext_range),
  .pix_clk(pix_clk), .pix_valid(pix_valid), .y_out(y_out), .cb_out(cb_out),
  .cr_out(cr_out), .hs_n_out(hs_n_out), .vs_n_out(vs_n_out),
  .blank_n_out(blank_n_out), .field_out(field_out)
);

// File: tb/vid_in_decoder_test.sv
`timescale 1ns/1ps
module vid_in_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic ext = 1'b0;
  logic [9:0] yi = '0, ci = '0, bi = '0;
  logic vsi = 1'b1, hsi = 1'b1, bli = 1'b0;
  logic pck, val, hso, vso, blo, fdo;
  logic [9:0] yo, cbo, cro;

  int checks = 0;
  int fails = 0;
  bit cmp_en = 0;

  int m_ph, m_wc, m_bprev, m_f, m_v, m_h;
  int m_cb, m_cr, m_y0, m_y1, m_pcb, m_pcr;
  int e_val, e_y, e_cb, e_cr, e_hs, e_vs, e_bl, e_fd;
  int hist[$];
  int idx, crn;
  bit rise, trs;

  always #4 clk = ~clk;

  vid_in_decoder uut (
    .clk2x(clk), .rst_n(rst_n), .fmt_sel(mode), .ext_range(ext),
    .luma_in(yi), .chroma_in(ci), .aux_in(bi),
    .vs_n_in(vsi), .hs_n_in(hsi), .blank_n_in(bli),
    .pix_clk(pck), .pix_valid(val), .y_out(yo), .cb_out(cbo), .cr_out(cro),
    .hs_n_out(hso), .vs_n_out(vso), .blank_n_out(blo), .field_out(fdo)
  );

  function automatic int clip(int v);
    int lo = ext ? 4 : 64;
    int hi = ext ? 1016 : 940;
    if (mode == 2'd3) return v;
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Behavioural reference model, one step per word clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_wc = 0; m_bprev = 1; m_f = 0; m_v = 0; m_h = 0;
      m_cb = 0; m_cr = 0; m_y0 = 0; m_y1 = 0; m_pcb = 0; m_pcr = 0;
      e_val = 0; e_y = 0; e_cb = 0; e_cr = 0; e_hs = 1; e_vs = 1; e_bl = 1; e_fd = 0;
      hist = '{0, 0, 0};
    end else begin
      m_ph = 1 - m_ph;
      rise = (mode != 2'd0) && bli && (m_bprev == 0);
      m_bprev = bli;
      idx = rise ? 0 : m_wc;
      trs = (mode == 2'd0) && hist[2] == 1023 && hist[1] == 0 && hist[0] == 0;
      crn = (mode < 2) ? m_cr : int'(ci);
      e_val = idx % 2;
      if (idx % 2 == 1) begin
        if (mode == 2'd3) begin
          e_y = yi; e_cb = bi; e_cr = ci;
        end else if (idx == 3) begin
          e_y = clip(m_y0); e_cb = clip(m_cb); e_cr = clip(crn);
        end else begin
          e_y = clip(m_y1); e_cb = clip(m_pcb); e_cr = clip(m_pcr);
        end
        if (mode == 2'd0) begin
          e_hs = 1 - m_h; e_vs = 1 - m_v; e_bl = (m_h || m_v) ? 0 : 1; e_fd = m_f;
        end else begin
          e_hs = hsi; e_vs = vsi; e_bl = bli; e_fd = 0;
        end
      end
      if (idx == 0 && mode < 2) m_cb = yi;
      if (idx == 1) begin
        m_y0 = yi;
        if (mode >= 2) m_cb = ci;
      end
      if (idx == 2 && mode < 2) m_cr = yi;
      if (idx == 3) begin
        m_y1 = yi; m_pcb = m_cb; m_pcr = crn;
      end
      if (trs) begin
        m_f = yi[8]; m_v = yi[7]; m_h = yi[6];
      end
      m_wc = (trs && !yi[6]) ? 0 : (idx + 1) % 4;
      hist.push_front(int'(yi));
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string dtag();
    if (mode == 2'd3) return "R10";
    if (mode == 2'd2) return "R7";
    return "R5";
  endfunction

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R2", "pix_clk", pck, m_ph);
      chk("R3", "pix_valid", val, e_val);
      chk(dtag(), "y_out", yo, e_y);
      chk(dtag(), "cb_out", cbo, e_cb);
      chk(dtag(), "cr_out", cro, e_cr);
      chk(mode == 2'd0 ? "R4" : "R6", "hs_n_out", hso, e_hs);
      chk(mode == 2'd0 ? "R4" : "R6", "vs_n_out", vso, e_vs);
      chk(mode == 2'd0 ? "R4" : "R6", "blank_n_out", blo, e_bl);
      chk(mode == 2'd0 ? "R4" : "R6", "field_out", fdo, e_fd);
    end
  end

  task automatic do_reset(logic [1:0] m, logic e);
    @(negedge clk);
    cmp_en = 0;
    rst_n = 0; mode = m; ext = e;
    yi = '0; ci = '0; bi = '0; vsi = 1; hsi = 1; bli = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "pix_valid", val, 0);
    chk("R1", "pix_clk", pck, 0);
    chk("R1", "y_out", yo, 0);
    chk("R1", "cb_out", cbo, 0);
    chk("R1", "hs_n_out", hso, 1);
    chk("R1", "vs_n_out", vso, 1);
    chk("R1", "blank_n_out", blo, 1);
    chk("R1", "field_out", fdo, 0);
    cmp_en = 1;
  endtask

  task automatic put(int y, int c, int b, bit vs, bit hs, bit bl);
    @(negedge clk);
    yi = 10'(y); ci = 10'(c); bi = 10'(b); vsi = vs; hsi = hs; bli = bl;
  endtask

  task automatic pw(int y);
    put(y, 0, 0, 1, 1, 0);
  endtask

  task automatic px(string tag, int y, int cb, int cr);
    chk(tag, "strobe", val, 1);
    chk(tag, "y_out", yo, y);
    chk(tag, "cb_out", cbo, cb);
    chk(tag, "cr_out", cro, cr);
  endtask

  function automatic int ctl(int f, int v, int h);
    return 512 | (f << 8) | (v << 7) | (h << 6) | (int'($urandom_range(0, 15)) << 2);
  endfunction

  task automatic emb_line(int f, int v, int n);
    pw(1023); pw(0); pw(0); pw(ctl(f, v, 1));
    for (int i = 0; i < 4; i++) begin pw(512); pw(64); end
    pw(1023); pw(0); pw(0); pw(ctl(f, v, 0));
    for (int i = 0; i < 4 * n; i++) pw(int'($urandom_range(1, 1022)));
  endtask

  task automatic ext_lines(int n);
    for (int l = 0; l < n; l++) begin
      for (int i = 0; i < 6; i++)
        put(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
            int'($urandom_range(0, 1023)), $urandom_range(0, 1), 0, 0);
      for (int i = 0; i < 4 * int'($urandom_range(2, 6)); i++)
        put(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
            int'($urandom_range(0, 1023)), $urandom_range(0, 1), $urandom_range(0, 1), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset, then R4/R5/R8 with embedded timing
    do_reset(2'd0, 1'b0);
    pw(1023); pw(0); pw(0); pw(ctl(1, 1, 1));
    pw(1023); pw(0); pw(0); pw(ctl(1, 1, 0));
    pw(256); pw(16); pw(1008); pw(768);
    pw(512);
    px("R5", 64, 256, 940);
    chk("R8", "y_out low clamp", yo, 64);
    chk("R4", "field_out", fdo, 1);
    chk("R4", "vs_n_out", vso, 0);
    chk("R4", "hs_n_out", hso, 1);
    chk("R4", "blank_n_out", blo, 0);
    pw(416);
    chk("R3", "no strobe after index 0", val, 0);
    pw(384);
    px("R5", 768, 256, 940);
    for (int l = 0; l < 12; l++) emb_line(l % 2, (l % 5 == 0) ? 1 : 0, 10 + l);

    // R6 external timing
    do_reset(2'd1, 1'b0);
    put(5, 0, 0, 1, 1, 0); put(9, 0, 0, 1, 1, 0);
    put(336, 0, 0, 0, 1, 1); put(96, 0, 0, 0, 1, 1);
    put(592, 0, 0, 0, 1, 1); put(112, 0, 0, 0, 1, 1);
    put(273, 0, 0, 1, 0, 1);
    px("R6", 96, 336, 592);
    chk("R6", "vs_n_out", vso, 0);
    chk("R6", "hs_n_out", hso, 1);
    chk("R6", "blank_n_out", blo, 1);
    chk("R6", "field_out", fdo, 0);
    ext_lines(10);

    // R7 and R8 boundaries, 20-bit
    do_reset(2'd2, 1'b0);
    put(1, 1, 0, 1, 1, 0);
    put(1023, 1023, 0, 1, 1, 1); put(273, 170, 0, 1, 1, 1);
    put(1023, 1023, 0, 1, 1, 1); put(546, 187, 0, 1, 1, 1);
    put(1023, 1023, 0, 1, 1, 1);
    px("R7", 273, 170, 187);
    put(63, 941, 0, 1, 1, 1); put(1023, 1023, 0, 1, 1, 1);
    px("R7", 546, 170, 187);
    put(64, 940, 0, 1, 1, 1); put(0, 0, 0, 1, 1, 1);
    px("R8", 64, 940, 940);
    put(500, 500, 0, 1, 1, 1); put(0, 0, 0, 1, 1, 1);
    px("R8", 64, 940, 940);
    ext_lines(10);

    // R9 extended range
    do_reset(2'd2, 1'b1);
    put(1, 1, 0, 1, 1, 0);
    put(9, 9, 0, 1, 1, 1); put(0, 1023, 0, 1, 1, 1);
    put(9, 9, 0, 1, 1, 1); put(1022, 2, 0, 1, 1, 1);
    put(9, 9, 0, 1, 1, 1);
    px("R9", 4, 1016, 4);
    put(9, 9, 0, 1, 1, 1); put(9, 9, 0, 1, 1, 1);
    px("R9", 1016, 1016, 4);
    ext_lines(8);
    do_reset(2'd0, 1'b1);
    for (int l = 0; l < 6; l++) emb_line(l % 2, 0, 12);

    // R10 pass-through
    do_reset(2'd3, 1'b0);
    put(7, 7, 7, 1, 1, 0);
    put(341, 341, 341, 1, 1, 1); put(1023, 1, 2, 0, 0, 1);
    put(341, 341, 341, 1, 1, 1);
    px("R10", 1023, 2, 1);
    chk("R10", "vs_n_out", vso, 0);
    put(0, 0, 0, 1, 1, 1); put(9, 9, 9, 1, 1, 1);
    px("R10", 0, 0, 0);
    ext_lines(10);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule